// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low address bits for a four-beat burst. A load pulse seeds it with the low bits of the first address, and each advance pulse then steps it to the next beat. The upper address bits are held elsewhere and are concatenated with this block's output to form the full address. The same sequencing serves read bursts and write bursts alike.

Two beat orders are supported, and a static order-select input picks one of them. In sequential order the beat address is the seed plus the number of advances taken, modulo four. In interleaved order it is the seed XORed with that number. Both orders wrap around and never saturate.

The sequencer keeps the seed and a beat count in separate registers. The output is formed from those two registers by a small mapping stage, so it changes in the cycle that follows the load or advance edge.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset is released, with no load yet seen, `addr_o` is 0.
- R2: When `load_i` is 1 at a rising edge, `addr_o` equals the `start_i` sampled at that edge from the next cycle on.
- R3: With `mode_i` = 0 (sequential order), the k-th advance after a load gives `addr_o` = (start + k) mod 4.
- R4: With `mode_i` = 1 (interleaved order), the k-th advance after a load gives `addr_o` = start XOR (k mod 4), so a seed of 1 yields 1, 0, 3, 2.
- R5: After four advances the sequence wraps back to the seed in both orders and keeps cycling; it never saturates.
- R6: When `load_i` and `adv_i` are both 1 at the same edge, the load wins: `addr_o` shows the new seed, and the beat count restarts from zero.
- R7: When neither `load_i` nor `adv_i` is 1 at an edge, `addr_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Seeds the sequencer from `start_i` and clears the beat count |
| adv_i | input | 1 | Moves to the next beat when 1 at an edge |
| start_i | input | CNT_W (2) | Low bits of the burst's first address |
| mode_i | input | 1 | Order select: 0 sequential, 1 interleaved |
| addr_o | output | CNT_W (2) | Current low address bits of the burst |

## Verification
The step properties assume that `mode_i` holds still between a load and the advances that follow it. Each property is written so that a cycle in which the mode changes releases it. The bench sets the mode only while the sequencer is idle and then applies a fresh load. It covers every seed in both orders, advancing past the wrap point each time, and adds idle cycles and coincident load-and-advance edges.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic {
        ORD_SEQUENTIAL = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

endpackage

// File: rtl/bseq_next.sv
// Next-state logic for seed and beat count. A load takes priority over an advance.
module bseq_next #(
    parameter int CNT_W = 2
) (
    input  logic             load,
    input  logic             adv,
    input  logic [CNT_W-1:0] seed_in,
    input  logic [CNT_W-1:0] seed_q,
    input  logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] seed_d,
    output logic [CNT_W-1:0] count_d
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        seed_d  = seed_q;
        count_d = count_q;
        if (load) begin
            seed_d  = seed_in;
            count_d = '0;
        end else if (adv) begin
            count_d = count_q + ONE;   // wraps at 2**CNT_W
        end
    end

endmodule

// File: rtl/bseq_map.sv
// Maps seed and beat count to a beat address in the selected order.
module bseq_map
    import bseq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] seed,
    input  logic [CNT_W-1:0] count,
    input  order_e           order,
    output logic [CNT_W-1:0] addr
);

    logic [CNT_W-1:0] seq_addr;
    logic [CNT_W-1:0] ilv_addr;

    assign seq_addr = seed + count;

    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_addr[b] = seed[b] ^ count[b];
    end

    always_comb begin
        unique case (order)
            ORD_INTERLEAVE: addr = ilv_addr;
            default:        addr = seq_addr;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bseq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic             mode_i,
    output logic [CNT_W-1:0] addr_o
);

    typedef struct packed {
        logic [CNT_W-1:0] seed;
        logic [CNT_W-1:0] count;
    } bseq_state_t;

    bseq_state_t st_d, st_q;
    logic [CNT_W-1:0] seed_nx, count_nx;
    order_e order;

    assign order = order_e'(mode_i);

    bseq_next #(.CNT_W(CNT_W)) u_next (
        .load    (load_i),
        .adv     (adv_i),
        .seed_in (start_i),
        .seed_q  (st_q.seed),
        .count_q (st_q.count),
        .seed_d  (seed_nx),
        .count_d (count_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.seed  = seed_nx;
        st_d.count = count_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bseq_map #(.CNT_W(CNT_W)) u_map (
        .seed  (st_q.seed),
        .count (st_q.count),
        .order (order),
        .addr  (addr_o)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             adv_i,
    input logic [CNT_W-1:0] start_i,
    input logic             mode_i,
    input logic [CNT_W-1:0] addr_o
);

    // R2: a load shows its seed on the next cycle
    a_r2_load_seed: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(start_i));

    // R6: a load beats a coincident advance
    a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && adv_i) |=> addr_o == $past(start_i));

    // R7: idle edges hold the address (unless the mode was changed)
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> ($stable(addr_o) || !$stable(mode_i)));

    // R3: a sequential step adds one, modulo the burst length
    a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && !mode_i) |=>
            (addr_o == CNT_W'($past(addr_o) + 1'b1) || !$stable(mode_i)));

    // R4: every interleaved step flips the lowest bit
    a_r4_ilv_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && mode_i) |=>
            (addr_o[0] != $past(addr_o[0]) || !$stable(mode_i)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic       adv_i = 1'b0;
    logic [1:0] start_i = '0;
    logic       mode_i = 1'b0;
    logic [1:0] addr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen #(.CNT_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
        .start_i(start_i), .mode_i(mode_i), .addr_o(addr_o)
    );

    function automatic logic [1:0] expect_addr(input logic [1:0] s, input int k, input logic m);
        logic [1:0] kk;
        kk = 2'(k % 4);
        return m ? (s ^ kk) : 2'(s + kk);
    endfunction

    task automatic check(input string req, input logic [1:0] exp);
        n_chk++;
        if (addr_o !== exp) begin
            n_fail++;
            $display("FAIL %s: addr_o=%0d expected=%0d", req, addr_o, exp);
        end
    endtask

    // set inputs after a falling edge; return after the next falling edge
    task automatic cyc(input logic ld, input logic av, input logic [1:0] s);
        load_i = ld; adv_i = av; start_i = s;
        @(negedge clk);
        load_i = 1'b0; adv_i = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 2'd0);

        for (int m = 0; m < 2; m++) begin
            mode_i = m[0];
            @(negedge clk);
            for (int s = 0; s < 4; s++) begin
                cyc(1'b1, 1'b0, 2'(s));
                check("R2", 2'(s));
                for (int k = 1; k <= 9; k++) begin
                    cyc(1'b0, 1'b1, 2'd0);
                    if (k % 4 == 0) check("R5", 2'(s));
                    else check(m ? "R4" : "R3", expect_addr(2'(s), k, m[0]));
                    if (k == 2) begin
                        cyc(1'b0, 1'b0, 2'(s + 1));
                        check("R7", expect_addr(2'(s), 2, m[0]));
                    end
                end
                // coincident load and advance mid-burst
                cyc(1'b1, 1'b1, 2'(3 - s));
                check("R6", 2'(3 - s));
                cyc(1'b0, 1'b1, 2'd0);
                check("R6", expect_addr(2'(3 - s), 1, m[0]));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule